// File: doc/BRIEF.md
# I2S Square-Wave Tone Transmitter

This block drives a stereo I2S digital-to-analog converter from a single master clock that runs at 512 times the sample rate (24.576 MHz for 48 kHz). One free-running counter divides the master clock into the bit clock (divide by 8) and the word-select clock (divide by 512). The same counter also selects which bit of the current stereo frame is on the serial data line. The master clock is passed through unchanged, so the converter can use it as its system clock.

Each 64-bit frame has two 32-bit slots: left while word-select is low, right while it is high. The left slot carries a 16-bit two's-complement sample from a built-in sequencer. The sequencer plays a symmetric square wave: a number of frames at a positive level, then a number of frames at a negative level, repeating. With the defaults of 60 and 60 frames, the tone is 400 Hz. The right slot is always zero. The run lengths and both levels are parameters, so short sequences can be simulated.

Top module: `i2s_tone_tx`

## Requirements
- R1: `bclk_o` divides `clk` by 8. In each bit period it is low for 4 clock cycles and then high for 4. After reset is released, its first rising edge comes 4 clock cycles later.
- R2: `ws_o` has a period of 64 bit periods. Number the bit periods of a frame 0 to 63, starting at reset. `ws_o` is high in bit periods 31 through 62 and low in all the others. Low selects the left channel and high selects the right channel.
- R3: `ws_o` and `sd_o` change only in the clock cycle where `bclk_o` falls.
- R4: The left sample is sent MSB first in bit periods 0 to 15. Bit periods 16 to 31 are zero. `ws_o` therefore falls one bit period before the left MSB and rises one bit period before the right MSB.
- R5: The left sample is `HI_VAL` (default 16'h7FFF) for `HI_CNT` frames, then `LO_VAL` (default 16'h8001) for `LO_CNT` frames, and this repeats.
- R6: `rst` is active high and synchronous. It puts the block at clock phase 0 of bit period 0 of a left slot, with `bclk_o` low and `ws_o` low. The sequencer is set to the first frame of the high run.
- R7: The sample position advances once per frame, in the cycle where `ws_o` falls. The runs of equal left words last exactly `HI_CNT` and `LO_CNT` frames, including the runs on either side of the point where the sequence wraps.
- R8: Every bit of the right slot is zero in every frame.
- R9: `mclk_o` follows `clk` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 512 x sample rate |
| rst | input | 1 | Synchronous reset, active high |
| mclk_o | output | 1 | Master clock passed through to the converter |
| bclk_o | output | 1 | Bit clock, master clock divided by 8 |
| ws_o | output | 1 | Word select: low = left, high = right |
| sd_o | output | 1 | Serial data, MSB first, changes on falling bit-clock edge |

## Verification
Two events can fall in the same clock cycle: a reset and the sequencer advance that happens at the falling edge of word-select. When both fall in one cycle, the reset must win, and the sequence must restart at the first high frame without skipping a frame. The bench provokes this by asserting reset in exactly the cycle that would advance the sequencer. It does this once inside a high run and once at the wrap from the last low frame. It also applies resets at random points in the frame. After each reset, the bench decodes the serial line on bit-clock rising edges and compares every left word and every run length with a model built from the frame count since reset.

// File: rtl/i2s_tone_tx.sv
module i2s_tone_tx #(
  parameter int SMP_W    = 16,
  parameter int SLOT_W   = 32,
  parameter int DIV_LOG2 = 3,
  parameter int HI_CNT   = 60,
  parameter int LO_CNT   = 60,
  parameter logic [SMP_W-1:0] HI_VAL = 16'h7FFF,
  parameter logic [SMP_W-1:0] LO_VAL = 16'h8001
) (
  input  logic clk,
  input  logic rst,
  output logic mclk_o,
  output logic bclk_o,
  output logic ws_o,
  output logic sd_o
);
  localparam int DIV        = 1 << DIV_LOG2;
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int CNT_W      = DIV_LOG2 + BIT_W;
  localparam int PER        = HI_CNT + LO_CNT;
  localparam int RUN_W      = $clog2(PER);
  localparam int ADV_AT     = (FRAME_BITS - 1) * DIV - 1;

  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bit_idx;
  logic [RUN_W-1:0] run, run_nx;
  logic [SMP_W-1:0] smp, smp_sh;
  logic             adv;

  assign bit_idx = cnt[CNT_W-1:DIV_LOG2];
  assign mclk_o  = clk;
  assign bclk_o  = cnt[DIV_LOG2-1];
  assign ws_o    = (bit_idx >= BIT_W'(SLOT_W - 1)) && (bit_idx != BIT_W'(FRAME_BITS - 1));
  assign smp_sh  = smp << bit_idx;
  assign sd_o    = (bit_idx < BIT_W'(SMP_W)) ? smp_sh[SMP_W-1] : 1'b0;

  assign adv    = (cnt == CNT_W'(ADV_AT));
  assign run_nx = (run == RUN_W'(PER - 1)) ? '0 : run + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= '0;
      smp <= HI_VAL;
    end else begin
      cnt <= cnt + 1'b1;
      if (adv) begin
        run <= run_nx;
        smp <= (run_nx < RUN_W'(HI_CNT)) ? HI_VAL : LO_VAL;
      end
    end
  end
endmodule

module i2s_tone_tx_chk #(
  parameter int DIV    = 8,
  parameter int SLOT_W = 32
) (
  input logic clk,
  input logic rst,
  input logic bclk,
  input logic ws,
  input logic sd
);
  logic bclk_d, ws_d, rise_seen, wfall_seen;
  int   ph_cnt, rise_cnt;
  logic rise, wfall;

  assign rise  = bclk && !bclk_d;
  assign wfall = !ws && ws_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d     <= 1'b0;
      ws_d       <= 1'b0;
      rise_seen  <= 1'b0;
      wfall_seen <= 1'b0;
      ph_cnt     <= 0;
      rise_cnt   <= 0;
    end else begin
      bclk_d <= bclk;
      ws_d   <= ws;
      if (rise) begin
        rise_seen <= 1'b1;
        ph_cnt    <= 1;
      end else begin
        ph_cnt <= ph_cnt + 1;
      end
      if (wfall) begin
        wfall_seen <= 1'b1;
        rise_cnt   <= 0;
      end else if (rise) begin
        rise_cnt <= rise_cnt + 1;
      end
    end
  end

  // R1
  bclk_period_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && rise_seen) |-> (ph_cnt == DIV));

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    (wfall && wfall_seen) |-> (rise_cnt == 2 * SLOT_W));

  // R3
  ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (ws != $past(ws)) |-> (!bclk && $past(bclk)));

  // R3
  sd_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (sd != $past(sd)) |-> (!bclk && $past(bclk)));

  // R8
  right_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ws |-> !sd);

  // R6
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!bclk && !ws));
endmodule

bind i2s_tone_tx i2s_tone_tx_chk #(.DIV(1 << DIV_LOG2), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .bclk(bclk_o), .ws(ws_o), .sd(sd_o)
);

// File: tb/i2s_tone_tx_tb.sv
module i2s_tone_tx_tb;
  localparam int DIV  = 8;
  localparam int SLOT = 32;
  localparam int HI   = 5;
  localparam int LO   = 3;
  localparam int FCYC = DIV * 2 * SLOT;
  localparam logic [15:0] HV = 16'h7FFF;
  localparam logic [15:0] LV = 16'h8001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mclk, bclk, ws, sd;
  int errs = 0;
  int checks = 0;
  int cyc = 0;
  int run_len = 0;
  logic [15:0] word = '0;
  logic [15:0] run_val = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2s_tone_tx #(.HI_CNT(HI), .LO_CNT(LO)) u_dut (
    .clk(clk), .rst(rst), .mclk_o(mclk), .bclk_o(bclk), .ws_o(ws), .sd_o(sd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at cyc %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int fr);
    return ((fr % (HI + LO)) < HI) ? HV : LV;
  endfunction

  function automatic bit exp_ws(input int b);
    return (b >= SLOT - 1) && (b < 2 * SLOT - 1);
  endfunction

  function automatic bit exp_sd(input int fr, input int b);
    logic [15:0] w;
    w = exp_word(fr);
    return (b < 16) ? w[15 - b] : 1'b0;
  endfunction

  task automatic do_reset(input int n);
    rst = 1'b1;
    repeat (n) @(negedge clk);
    // R6 reset state
    chk(bclk == 1'b0, "R6 bclk", bclk, 0);
    chk(ws == 1'b0, "R6 ws", ws, 0);
    chk(sd == exp_sd(0, 0), "R6 sd", sd, exp_sd(0, 0));
    @(posedge clk);
    #1;
    // R9 pass-through while clk is high
    chk(mclk == 1'b1, "R9 mclk", mclk, 1);
    @(negedge clk);
    chk(mclk == 1'b0, "R9 mclk", mclk, 0);
    rst = 1'b0;
    cyc = 0;
    run_len = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      int ph, b, fr;
      ph = cyc % DIV;
      b  = (cyc / DIV) % (2 * SLOT);
      fr = cyc / FCYC;
      chk(bclk == (ph >= DIV / 2), "R1 bclk", bclk, ph >= DIV / 2);
      chk(ws == exp_ws(b), "R2 ws", ws, exp_ws(b));
      chk(sd == exp_sd(fr, b), ph == 0 ? "R4 sd" : "R3 sd hold", sd, exp_sd(fr, b));
      if (ph == DIV / 2) begin
        word = {word[14:0], sd};
        if (b == 15) begin
          chk(word == exp_word(fr), "R5 left word", word, exp_word(fr));
          if (fr == 0) begin
            run_val = word;
            run_len = 1;
          end else if (word != run_val) begin
            // R7 run length at each level change
            chk(run_len == ((run_val == HV) ? HI : LO), "R7 run length", run_len,
                (run_val == HV) ? HI : LO);
            run_val = word;
            run_len = 1;
          end else begin
            run_len++;
          end
        end
        if (b == 47) chk(word == 16'h0, "R8 right word", word, 0);
        if (b == 31) chk(word == 16'h0, "R4 left pad", word, 0);
      end
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    do_reset(3);
    run(2 * (HI + LO) * FCYC);
    // reset in the advance cycle inside a high run (R7, R6)
    run(2 * FCYC + FCYC - DIV - 1);
    do_reset(1);
    run(2 * (HI + LO) * FCYC);
    // reset in the advance cycle at the wrap from the last low frame
    run((HI + LO) * FCYC - DIV - 1);
    do_reset(2);
    run((HI + LO + 2) * FCYC);
    for (int k = 0; k < 6; k++) begin
      run($urandom_range(FCYC * 3, 200));
      do_reset($urandom_range(4, 1));
    end
    run((HI + LO + 1) * FCYC);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule